// File: doc/BRIEF.md
# Four-by-Four Unsigned Tree Multiplier

This block multiplies two unsigned 4-bit operands and returns the full 8-bit product with no clock and no state. Sixteen AND gates form the partial-product bits. Each bit is filed into the column of its binary weight. A fixed two-level tree of 3:2 and 2:2 counters then cuts every column down to at most two bits. A ripple adder merges the two remaining rows into the upper seven product bits. The lowest product bit leaves the array directly.

The tree is fixed. The first level puts one half adder on column 3 and one on column 4. The second level puts a half adder on column 2 and full adders on columns 3, 4 and 5. That makes three half adders and three full adders in total. Every counter leaves its sum in its own column and passes its carry one column up, into the next level. The block is meant to sit inside a wider datapath as a small, regular multiply leaf.

Top module: `wt_mul4`

## Requirements
- R1: For every pair of operands x and y in 0..15, z equals the unsigned product x*y.
- R2: Product bit z[0] equals x[0] AND y[0] and passes through no adder.
- R3: The partial-product bit formed from x[i] and y[j] carries weight 2^(i+j). With x = 2^i and y = 2^j, z equals 2^(i+j).
- R4: Every counter cell satisfies 2*carry + sum = the number of its inputs that are 1. A half adder has two inputs and a full adder has three.
- R5: After the second reduction level, the two rows covering columns 1 to 6 satisfy z[0] + 2*(rowA + rowB) = x*y.
- R6: The final adder returns z[7:1] = rowA + rowB. Its carry out is z[7].
- R7: With both operands at 15, the carry reaches the top bit and z = 225.
- R8: If either operand is zero, z is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 4 | Unsigned multiplicand |
| y | input | 4 | Unsigned multiplier |
| z | output | 8 | Unsigned product x*y |

## Verification
The bench applies one-hot operand pairs. These catch any partial product that is swapped into the wrong column: such a design returns a power of two at the wrong weight. The all-ones pair drives every counter and the final carry at once, so a carry routed to its own column instead of the next one up shows as a result below 225. Operands where one side is zero, or where a single bit is set, expose a counter whose sum and carry are exchanged. All 256 pairs are then compared against a shift-and-add model in the bench, so a mistake in any single cell shows as a wrong product.

// File: rtl/wt_mul_pkg.sv
package wt_mul_pkg;
  localparam int OPW  = 4;
  localparam int PRW  = 2 * OPW;
  localparam int ROWW = PRW - 2;

  typedef struct packed {
    logic c;
    logic s;
  } cnt_t;

  function automatic cnt_t half_cnt(input logic a, input logic b);
    cnt_t r;
    r.s = a ^ b;
    r.c = a & b;
    return r;
  endfunction

  function automatic cnt_t full_cnt(input logic a, input logic b, input logic ci);
    cnt_t r;
    r.s = a ^ b ^ ci;
    r.c = (a & b) | (a & ci) | (b & ci);
    return r;
  endfunction
endpackage

// File: rtl/wt_pp_array.sv
module wt_pp_array
  import wt_mul_pkg::*;
(
  input  logic [OPW-1:0]           x,
  input  logic [OPW-1:0]           y,
  output logic [OPW-1:0][OPW-1:0]  pp
);
  for (genvar i = 0; i < OPW; i++) begin : g_row
    for (genvar j = 0; j < OPW; j++) begin : g_col
      assign pp[i][j] = x[i] & y[j];
    end
  end

  always_comb begin
    // R3
    r3_ppbit_chk: assert (pp[OPW-1][0] == (x[OPW-1] & y[0]));
  end
endmodule

// File: rtl/wt_cnt_cell.sv
module wt_cnt_cell
  import wt_mul_pkg::*;
#(
  parameter bit FULL = 1'b1
) (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  cnt_t r;
  logic ci_eff;

  if (FULL) begin : g_full
    assign r      = full_cnt(a, b, ci);
    assign ci_eff = ci;
  end else begin : g_half
    logic unused_ci;
    assign unused_ci = ci;
    assign r         = half_cnt(a, b);
    assign ci_eff    = 1'b0;
  end

  assign s  = r.s;
  assign co = r.c;

  always_comb begin
    // R4
    r4_count_chk: assert ({co, s} == (2'(a) + 2'(b) + 2'(ci_eff)));
  end
endmodule

// File: rtl/wt_merge_add.sv
module wt_merge_add #(
  parameter int W = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign sum[k]  = a[k] ^ b[k] ^ c[k];
    assign c[k+1]  = (a[k] & b[k]) | (c[k] & (a[k] ^ b[k]));
  end
  assign co = c[W];

  always_comb begin
    // R6
    r6_merge_chk: assert ({co, sum} == ((W+1)'(a) + (W+1)'(b)));
  end
endmodule

// File: rtl/wt_mul4.sv
module wt_mul4
  import wt_mul_pkg::*;
(
  input  logic [OPW-1:0] x,
  input  logic [OPW-1:0] y,
  output logic [PRW-1:0] z
);
  logic [OPW-1:0][OPW-1:0] pp;

  wt_pp_array u_pp (.x(x), .y(y), .pp(pp));

  // level 1: half adders on columns 3 and 4
  logic s3a, c4a, s4b, c5b;
  wt_cnt_cell #(.FULL(1'b0)) u_l1_c3 (.a(pp[3][0]), .b(pp[2][1]), .ci(1'b0), .s(s3a), .co(c4a));
  wt_cnt_cell #(.FULL(1'b0)) u_l1_c4 (.a(pp[3][1]), .b(pp[2][2]), .ci(1'b0), .s(s4b), .co(c5b));

  // level 2: half adder on column 2, full adders on columns 3..5
  logic s2c, c3c, s3d, c4d, s4e, c5e, s5f, c6f;
  wt_cnt_cell #(.FULL(1'b0)) u_l2_c2 (.a(pp[2][0]), .b(pp[1][1]), .ci(1'b0), .s(s2c), .co(c3c));
  wt_cnt_cell #(.FULL(1'b1)) u_l2_c3 (.a(pp[1][2]), .b(pp[0][3]), .ci(s3a),  .s(s3d), .co(c4d));
  wt_cnt_cell #(.FULL(1'b1)) u_l2_c4 (.a(pp[1][3]), .b(s4b),      .ci(c4a),  .s(s4e), .co(c5e));
  wt_cnt_cell #(.FULL(1'b1)) u_l2_c5 (.a(pp[3][2]), .b(pp[2][3]), .ci(c5b),  .s(s5f), .co(c6f));

  // two rows covering columns 1..6
  logic [ROWW-1:0] row_a, row_b;
  assign row_a = {pp[3][3], s5f, s4e, s3d, s2c, pp[1][0]};
  assign row_b = {c6f,      c5e, c4d, c3c, pp[0][2], pp[0][1]};

  logic [ROWW-1:0] hi_sum;
  logic            hi_co;
  wt_merge_add #(.W(ROWW)) u_add (.a(row_a), .b(row_b), .sum(hi_sum), .co(hi_co));

  assign z = {hi_co, hi_sum, pp[0][0]};

  always_comb begin
    // R1
    r1_product_chk: assert (z == (PRW'(x) * PRW'(y)));
    // R2
    r2_lsb_chk: assert (z[0] == (x[0] & y[0]));
    // R5
    r5_rows_chk: assert ((PRW'({row_a, 1'b0}) + PRW'({row_b, 1'b0}) + PRW'(pp[0][0]))
                         == (PRW'(x) * PRW'(y)));
    // R8
    r8_zero_chk: assert (!((x == '0) || (y == '0)) || (z == '0));
  end
endmodule

// File: tb/wt_mul4_tb.sv
module wt_mul4_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 12;
  // entries: {x[3:0], y[3:0], expected z[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd0,  4'd0,  8'd0},   {4'd15, 4'd15, 8'd225}, {4'd1,  4'd1,  8'd1},
    {4'd15, 4'd1,  8'd15},  {4'd1,  4'd15, 8'd15},  {4'd8,  4'd8,  8'd64},
    {4'd5,  4'd10, 8'd50},  {4'd10, 4'd5,  8'd50},  {4'd7,  4'd9,  8'd63},
    {4'd12, 4'd13, 8'd156}, {4'd3,  4'd11, 8'd33},  {4'd14, 4'd6,  8'd84}
  };

  logic       clk = 1'b0;
  logic [3:0] x = '0;
  logic [3:0] y = '0;
  logic [7:0] z;
  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  wt_mul4 u_dut (.x(x), .y(y), .z(z));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_mul(input logic [3:0] a, input logic [3:0] b);
    logic [7:0] acc = '0;
    for (int k = 0; k < 4; k++)
      if (b[k]) acc = acc + ({4'b0, a} << k);
    return acc;
  endfunction

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [7:0] exp_z,
                       input string req);
    @(negedge clk);
    x = a;
    y = b;
    #1;
    n_vec++;
    if (z !== exp_z) begin
      n_bad++;
      $display("FAIL %s x=%0d y=%0d actual=%0d expected=%0d", req, a, b, z, exp_z);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 table of known products (R7 entry 15x15 = 225, R8 entry 0x0)
    for (int v = 0; v < NVEC; v++)
      apply(VEC[v][15:12], VEC[v][11:8], VEC[v][7:0], "R1_table");
    // R8 zero operand on either side
    apply(4'd0, 4'd13, 8'd0, "R8");
    apply(4'd9, 4'd0,  8'd0, "R8");
    // R7 full carry to top bit
    apply(4'd15, 4'd15, 8'd225, "R7");
    // R3 each partial product lands at weight 2^(i+j)
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        apply(4'(1 << i), 4'(1 << j), 8'(1 << (i + j)), "R3");
    // R2 low bit is x0 AND y0 (odd*odd, odd*even)
    apply(4'd3, 4'd5, 8'd15, "R2");
    apply(4'd3, 4'd4, 8'd12, "R2");
    // R4 R5 R6 exhaustive sweep against shift-and-add model
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        apply(4'(a), 4'(b), model_mul(4'(a), 4'(b)), "R1_R4_R5_R6_sweep");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule